// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is an SPI bus master that software runs through five 32-bit registers on a simple single-cycle register bus. Words written to the transmit data register are queued in a transmit FIFO. A shift engine sends them on SCLK/MOSI and collects the bits coming back on MISO. Every shifted word lands in a receive FIFO, which software drains through the receive data register.

The control register sets clock polarity, clock phase, bit order and an internal loopback path. A transmit-hold bit lets software fill the queue before the first bit moves. Once the hold bit is cleared, the queued words go out one after another without software involvement.

The select lines come straight from a register in manual mode. In automatic mode, the register value is applied only while a word is being shifted. The serial clock rate is fixed when the block is built. Slave operation, fault detection and interrupt generation are not part of this block.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, control reads 0x000, status reads 0x005, the select register reads 0xFFFFFFFF, every select line is high and SCLK is low.
- R2: Control (offset 0x60) stores bit0 loopback, bit1 enable, bit2 master, bit3 clock polarity, bit4 clock phase, bit7 manual select, bit8 transmit hold and bit9 LSB first. Bits 5 and 6 always read as zero. Status (offset 0x64) reports bit0 RX empty, bit1 RX full, bit2 TX empty and bit3 TX full, and bit4 reads zero.
- R3: The transmit FIFO (push by a write to offset 0x68) holds 16 words. Status bit3 is set once 16 words are queued. A write to a full FIFO is dropped and leaves the flag set.
- R4: While control bit8 is set, queued words stay queued and SCLK does not toggle. Clearing bit8 sends every queued word in order with no further software action.
- R5: With control bit0 set, MOSI feeds the receive shifter, so every received word equals the transmitted word.
- R6: A word leaves MSB first when control bit9 is clear and LSB first when it is set. A word of zero is sent as all zeros.
- R7: SCLK idles at the level of control bit3. With bit4 clear, data is sampled on the leading edge and changed on the trailing edge. With bit4 set, data is changed on the leading edge and sampled on the trailing edge. A word driven on MISO by a slave is received intact in all four modes.
- R8: Writing 1 to control bit5 empties the transmit FIFO, and writing 1 to control bit6 empties the receive FIFO.
- R9: Each shifted word pushes one word into the receive FIFO (pop by a read of offset 0x6C). A word that completes while the receive FIFO is full is discarded, and RX full (status bit1) stays set.
- R10: The select register (offset 0x70) drives select line i from bit i. With control bit7 set, the lines follow the register at all times. With bit7 clear, the lines are all high while idle and follow the register while a word is shifted.
- R11: No word starts unless control bit1 and bit2 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at offset 0x6C) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave select lines |

## Verification
The embedded properties check the rules that are local in time on every cycle. No word starts while the hold bit is set or while the controller is disabled. SCLK sits at its polarity level whenever the engine is idle. A full transmit queue keeps its count when written. A finished word either adds exactly one receive entry or, when the receive queue is full, is dropped.

Data integrity can only be shown by the bench scenarios. These cover the bit order on MOSI, the edge that the slave model and the controller each sample on in every clock mode, and loopback equality. They also cover the exact 16-word limit, the back-to-back draining of a preloaded queue and the select line behaviour during a transfer.

// File: rtl/spi_master_regs.sv
module spi_master_regs #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_SS     = 8,
  parameter int CLK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  localparam int PW  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW  = $clog2(FIFO_DEPTH + 1);
  localparam int DVW = $clog2(CLK_DIV + 1);
  localparam int ECW = $clog2(2 * DATA_W + 1);
  localparam logic [7:0] A_CTRL = 8'h60;
  localparam logic [7:0] A_STAT = 8'h64;
  localparam logic [7:0] A_TXD  = 8'h68;
  localparam logic [7:0] A_RXD  = 8'h6C;
  localparam logic [7:0] A_SEL  = 8'h70;
  localparam logic [9:0] CTRL_KEEP = 10'h39F;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(FIFO_DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [9:0]  ctrl;
  logic [31:0] sel;
  wire c_loop = ctrl[0], c_en = ctrl[1], c_mst = ctrl[2], c_cpol = ctrl[3];
  wire c_cpha = ctrl[4], c_man = ctrl[7], c_hold = ctrl[8], c_lsb = ctrl[9];

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire tx_clr  = wr_ctrl && bus_wdata[5];
  wire rx_clr  = wr_ctrl && bus_wdata[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      sel  <= '1;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[9:0] & CTRL_KEEP;
      if (bus_wr && bus_addr == A_SEL) sel <= bus_wdata;
    end
  end

  // transmit queue
  logic [DATA_W-1:0] tx_mem [FIFO_DEPTH];
  logic [PW-1:0]     tx_wp, tx_rp;
  logic [CW-1:0]     tx_cnt;
  logic              start;
  wire tx_full  = tx_cnt == CW'(FIFO_DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire tx_push  = bus_wr && bus_addr == A_TXD && !tx_full;
  wire tx_pop   = start;

  always_ff @(posedge clk) begin
    if (tx_push && !tx_clr) tx_mem[tx_wp] <= bus_wdata[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_clr) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  // shift engine
  logic              busy, phase;
  logic [DVW-1:0]    div_cnt;
  logic [ECW-1:0]    edge_cnt;
  logic [DATA_W-1:0] tx_sr, rx_sr;

  assign start = !busy && c_en && c_mst && !c_hold && !tx_empty;

  wire             tick     = busy && div_cnt == DVW'(CLK_DIV - 1);
  wire [ECW-1:0]   edge_num = edge_cnt + ECW'(1);
  wire             leading  = edge_num[0];
  wire             smp_edge = tick && (leading ^ c_cpha);
  wire             last     = tick && edge_num == ECW'(2 * DATA_W);
  wire             shf_edge = tick && !(leading ^ c_cpha) &&
                              (c_cpha ? edge_num != ECW'(1) : !last);

  assign mosi = c_lsb ? tx_sr[0] : tx_sr[DATA_W-1];
  wire rx_in = c_loop ? mosi : miso;
  wire [DATA_W-1:0] rx_next = c_lsb ? {rx_in, rx_sr[DATA_W-1:1]}
                                    : {rx_sr[DATA_W-2:0], rx_in};
  wire [DATA_W-1:0] rx_word = smp_edge ? rx_next : rx_sr;
  wire word_done = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      phase    <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tx_sr    <= tx_mem[tx_rp];
      rx_sr    <= '0;
    end else if (busy) begin
      if (tick) begin
        div_cnt  <= '0;
        edge_cnt <= edge_num;
        phase    <= ~phase;
        if (smp_edge) rx_sr <= rx_next;
        if (shf_edge) tx_sr <= c_lsb ? (tx_sr >> 1) : (tx_sr << 1);
        if (last) busy <= 1'b0;
      end else begin
        div_cnt <= div_cnt + DVW'(1);
      end
    end
  end

  assign sclk = c_cpol ^ phase;
  assign ss_n = (c_man || busy || start) ? sel[NUM_SS-1:0] : '1;

  // receive queue
  logic [DATA_W-1:0] rx_mem [FIFO_DEPTH];
  logic [PW-1:0]     rx_wp, rx_rp;
  logic [CW-1:0]     rx_cnt;
  wire rx_full  = rx_cnt == CW'(FIFO_DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire rx_push  = word_done && !rx_full;
  wire rx_pop   = bus_rd && bus_addr == A_RXD && !rx_empty;

  always_ff @(posedge clk) begin
    if (rx_push && !rx_clr) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_clr) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {22'd0, ctrl};
      A_STAT:  bus_rdata = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
      A_RXD:   bus_rdata = rx_empty ? 32'd0 : 32'(rx_mem[rx_rp]);
      A_SEL:   bus_rdata = sel;
      default: bus_rdata = 32'd0;
    endcase
  end

  a_r4_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && c_hold) |=> !busy);

  a_r11_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(c_en && c_mst));

  a_r7_idle_clock_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == c_cpol);

  a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && bus_wr && bus_addr == A_TXD && !tx_pop && !tx_clr)
      |=> tx_cnt == CW'(FIFO_DEPTH));

  a_r9_full_rx_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_full && !rx_pop && !rx_clr) |=> rx_cnt == CW'(FIFO_DEPTH));

  a_r9_one_word_per_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !rx_full && !rx_pop && !rx_clr) |=> rx_cnt == $past(rx_cnt) + CW'(1));
endmodule

// File: tb/spi_master_regs_test.sv
module spi_master_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                         A_RXD = 8'h6C, A_SEL = 8'h70;
  // {loop, cpol, cpha, lsb} | tx word | slave word
  localparam logic [19:0] VEC [0:7] = '{
    20'h0A53C, 20'h296C3, 20'h45A81, 20'h6F00F,
    20'h10180, 20'h700E7, 20'h86DFF, 20'hBB200 };

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, miso = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi;
  logic [7:0] ss_n;
  int checks = 0, errors = 0;
  bit finished = 0;

  spi_master_regs uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model state
  logic [W-1:0] sl_word, sl_got;
  bit sl_cpha, sl_lsb;
  int sl_e = 0, sl_i = 0;

  function automatic logic pick(input logic [W-1:0] w, input int i, input bit lsb);
    return lsb ? w[i] : w[W-1-i];
  endfunction

  task automatic slave_arm(input logic [W-1:0] w, input bit cpha, input bit lsb);
    sl_word = w; sl_cpha = cpha; sl_lsb = lsb; sl_got = '0; sl_e = 0;
    if (cpha) begin sl_i = 0; miso = 1'b0; end
    else begin miso = pick(w, 0, lsb); sl_i = 1; end
  endtask

  initial begin
    forever begin
      @(sclk);
      if (!ss_n[0]) begin
        sl_e = sl_e + 1;
        if ((sl_e % 2 == 1) ^ sl_cpha)
          sl_got = sl_lsb ? {mosi, sl_got[W-1:1]} : {sl_got[W-2:0], mosi};
        else if (sl_i < W) begin
          miso = pick(sl_word, sl_i, sl_lsb);
          sl_i = sl_i + 1;
        end
        if (sl_e == 2 * W) begin
          sl_e = 0;
          sl_i = sl_cpha ? 0 : W;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_rx();
    logic [31:0] s;
    for (int k = 0; k < 1000; k++) begin
      rd(A_STAT, s);
      if (!s[0]) return;
    end
  endtask

  task automatic wait_tx_drained();
    logic [31:0] s;
    for (int k = 0; k < 2000; k++) begin
      rd(A_STAT, s);
      if (s[2]) break;
    end
    repeat (60) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); check("R1 status", d, 32'h5);
    rd(A_SEL, d);  check("R1 select reg", d, 32'hFFFFFFFF);
    check("R1 ss_n", {24'd0, ss_n}, 32'hFF);
    check("R1 sclk", {31'd0, sclk}, 32'h0);

    // R2 control bit layout
    wr(A_CTRL, 32'h3FF);
    rd(A_CTRL, d); check("R2 ctrl readback", d, 32'h39F);
    rd(A_STAT, d); check("R2 status bit4 zero", {31'd0, d[4]}, 32'h0);
    wr(A_CTRL, 32'h0);

    // R5 R6 R7 vector table
    wr(A_SEL, 32'hFFFFFFFE);
    for (int v = 0; v < 8; v++) begin
      logic [3:0] m;
      logic [7:0] txw, slw;
      logic [31:0] c;
      {m, txw, slw} = VEC[v];
      c = 32'h186 | (m[3] ? 32'h1 : 0) | (m[2] ? 32'h8 : 0) |
          (m[1] ? 32'h10 : 0) | (m[0] ? 32'h200 : 0);
      wr(A_CTRL, c);
      slave_arm(slw, m[1], m[0]);
      wr(A_TXD, {24'd0, txw});
      wr(A_CTRL, c & ~32'h100);
      wait_rx();
      repeat (4) @(negedge clk);
      check($sformatf("R7 idle sclk level vec%0d", v), {31'd0, sclk}, {31'd0, m[2]});
      check($sformatf("R6 mosi word seen by slave vec%0d", v), {24'd0, sl_got}, {24'd0, txw});
      rd(A_RXD, d);
      check($sformatf("R5/R7 received word vec%0d", v), d, {24'd0, m[3] ? txw : slw});
    end

    // R3 R4 R9 fill, hold, drain, overflow
    wr(A_CTRL, 32'h1E7);
    for (int i = 0; i < 17; i++) wr(A_TXD, 32'(i));
    rd(A_STAT, d); check("R3 tx full after 16 writes", d, 32'h9);
    repeat (100) @(negedge clk);
    rd(A_STAT, d); check("R4 nothing shifted while held", d, 32'h9);
    check("R4 sclk still while held", {31'd0, sclk}, 32'h0);
    wr(A_CTRL, 32'h087);
    wait_tx_drained();
    rd(A_STAT, d); check("R9 rx full after 16 words", d, 32'h6);
    wr(A_TXD, 32'h55);
    wait_tx_drained();
    rd(A_STAT, d); check("R9 rx full flag kept after discard", d, 32'h6);
    for (int i = 0; i < 16; i++) begin
      rd(A_RXD, d);
      check($sformatf("R3/R9 drained word %0d", i), d, 32'(i));
    end
    rd(A_STAT, d); check("R3 dropped 17th word absent", d, 32'h5);

    // R8 FIFO resets
    wr(A_CTRL, 32'h187);
    wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33);
    rd(A_STAT, d); check("R8 tx queued", d, 32'h1);
    wr(A_CTRL, 32'h1A7);
    rd(A_STAT, d); check("R8 tx reset empties", d, 32'h5);
    rd(A_CTRL, d); check("R2 reset bits read zero", d, 32'h187);
    wr(A_TXD, 32'h44); wr(A_TXD, 32'h66);
    wr(A_CTRL, 32'h087);
    wait_tx_drained();
    rd(A_STAT, d); check("R8 rx holds words", d, 32'h4);
    wr(A_CTRL, 32'h0C7);
    rd(A_STAT, d); check("R8 rx reset empties", d, 32'h5);

    // R11 enable and master gating
    wr(A_CTRL, 32'h081);
    wr(A_TXD, 32'h3A);
    repeat (100) @(negedge clk);
    rd(A_STAT, d); check("R11 no start while disabled", d, 32'h1);
    wr(A_CTRL, 32'h083);
    repeat (100) @(negedge clk);
    rd(A_STAT, d); check("R11 no start without master", d, 32'h1);
    wr(A_CTRL, 32'h087);
    wait_rx();
    repeat (40) @(negedge clk);
    rd(A_RXD, d); check("R11 sends once enabled", d, 32'h3A);

    // R10 select lines
    wr(A_SEL, 32'hFFFFFFFD);
    check("R10 manual follows register", {24'd0, ss_n}, 32'hFD);
    wr(A_CTRL, 32'h107);
    check("R10 auto idle high", {24'd0, ss_n}, 32'hFF);
    wr(A_TXD, 32'h5C);
    wr(A_CTRL, 32'h007);
    repeat (8) @(negedge clk);
    check("R10 auto active during word", {24'd0, ss_n}, 32'hFD);
    wait_rx();
    repeat (40) @(negedge clk);
    check("R10 auto released after word", {24'd0, ss_n}, 32'hFF);
    rd(A_RXD, d); check("R5 auto mode loopback word", d, 32'h5C);

    finish_run();
  end
endmodule